// File: doc/BRIEF.md
# Byte-Serial Load Sequencer

This block performs the memory-read phase of load-type instructions for a small 32-bit processor whose data memory delivers one byte per access. A single-cycle `start` hands over an already decoded load kind, two source register indices and a destination index. The sequencer works out the first byte address and marks one pending flag per byte still to be fetched. It then issues one byte read per cycle and assembles the returned bytes into a 32-bit word. When the last byte arrives it writes the destination register once, applies any stack-pointer or program-counter adjustment, and raises `done` for one cycle so the control path can begin the next instruction fetch.

A 16-entry register file model sits inside the block. Register 14 is the stack pointer and register 15 the program counter. An idle-time write port and a combinational read port let the surrounding pipeline preload and inspect register values. The memory is outside the block and is synchronous: read data appears one cycle after the address and read strobe are presented.

Top module: `byteserial_load_seq`

## Requirements
- R1: After reset `busy`, `done` and `mem_rd` are low and every register reads zero.
- R2: `cmd` encoding: 0 = byte load, 1 = word load, 2 = pop, 3 = immediate word load. A byte load performs exactly one memory read. The other three perform exactly four reads on consecutive cycles, starting in the cycle after `start` is accepted.
- R3: Byte and word loads start reading at the 32-bit wrapping sum of the two source registers. Each following read address is the previous one plus one.
- R4: A pop reads from the address in register 14. After completion register 14 holds its old value plus 4.
- R5: An immediate word load reads from the address in register 15. Register 15 reads old+2 from the cycle after acceptance and old+4 once `done` is high.
- R6: Multi-byte results are big-endian: the byte from the lowest address lands in bits 31:24 and the byte from the highest address in bits 7:0.
- R7: A byte load writes the fetched byte into bits 7:0 of the destination and zeros into bits 31:8.
- R8: Read data is taken one cycle after its address. `done` is high for exactly one cycle. With `start` accepted at clock edge k and N bytes to read, `done` is high in the cycle that follows edge k+N+1.
- R9: The destination register keeps its old value while the sequence runs. It shows the new value in the `done` cycle.
- R10: While `busy` is high, including the `done` cycle, both `start` and the register write port are ignored.
- R11: When a pop targets register 14, or an immediate load targets register 15, the pointer adjustment takes precedence over the loaded data.
- R12: While idle, `wr_en` writes `wr_data` into register `wr_idx` at the clock edge. `rd_data` always shows register `rd_idx` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept a load command (idle only) |
| cmd | input | 2 | Load kind, encoded as in R2 |
| src_a | input | 4 | First address source register index |
| src_b | input | 4 | Second address source register index |
| dst | input | 4 | Destination register index |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion, return to fetch |
| mem_rd | output | 1 | Byte read strobe |
| mem_addr | output | 32 | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the strobe |
| wr_en | input | 1 | Register write enable (idle only) |
| wr_idx | input | 4 | Register write index |
| wr_data | input | 32 | Register write data |
| rd_idx | input | 4 | Register read index |
| rd_data | output | 32 | Register read data |

## Verification
The pending-flag set drives both the read strobe and the end of the sequence. A flag that is dropped or stuck shows up as a wrong count of `mem_rd` cycles and as `done` arriving early or late, visible within at most five cycles of acceptance. A wrong byte slot or wrong address step shows as a wrong destination value or a wrong `mem_addr`, and shows no later than the `done` cycle. A misapplied pointer step shows in register 15 one cycle after acceptance, or in register 14 or 15 when `done` rises. Early destination writes can be seen mid-sequence through the read port.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  localparam int XLEN   = 32;
  localparam int NBYTES = XLEN / 8;
  localparam int SLOT_W = $clog2(NBYTES);

  typedef enum logic [1:0] {
    LK_BYTE = 2'd0,
    LK_WORD = 2'd1,
    LK_POP  = 2'd2,
    LK_IMM  = 2'd3
  } load_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_RUN    = 2'd1,
    SQ_RETIRE = 2'd2
  } seq_state_e;

  // Pending flags raised by a new command: only the top slot for a byte load.
  function automatic logic [NBYTES-1:0] flags_for(input load_kind_e k);
    logic [NBYTES-1:0] f;
    f = '0;
    if (k == LK_BYTE) f[NBYTES-1] = 1'b1;
    else              f = '1;
    return f;
  endfunction

  // Index of the highest set flag (the next byte slot to fetch).
  function automatic logic [SLOT_W-1:0] top_slot(input logic [NBYTES-1:0] p);
    logic [SLOT_W-1:0] s;
    s = '0;
    for (int i = 0; i < NBYTES; i++)
      if (p[i]) s = SLOT_W'(i);
    return s;
  endfunction

  // Clear the highest set flag.
  function automatic logic [NBYTES-1:0] drop_top(input logic [NBYTES-1:0] p);
    logic [NBYTES-1:0] m;
    m = '0;
    m[top_slot(p)] = 1'b1;
    return p & ~m;
  endfunction

  // Insert one byte into the given slot of the word.
  function automatic logic [XLEN-1:0] place_byte(input logic [XLEN-1:0] acc,
                                                 input logic [SLOT_W-1:0] slot,
                                                 input logic [7:0] b);
    logic [XLEN-1:0] r;
    r = acc;
    for (int i = 0; i < NBYTES; i++)
      if (slot == SLOT_W'(i)) r[i*8 +: 8] = b;
    return r;
  endfunction

  // Byte loads land in the top slot and are moved down and zero-extended.
  function automatic logic [XLEN-1:0] finish_value(input load_kind_e k,
                                                   input logic [XLEN-1:0] v);
    if (k == LK_BYTE) return {{(XLEN-8){1'b0}}, v[XLEN-1 -: 8]};
    return v;
  endfunction

  function automatic logic [XLEN-1:0] bump(input logic [XLEN-1:0] v, input int step);
    return v + XLEN'(step);
  endfunction

endpackage

// File: rtl/lsq_regfile.sv
module lsq_regfile
  import lsq_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int IDXW   = $clog2(NREG),
  parameter int SP_IDX = 14,
  parameter int PC_IDX = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_we,
  input  logic [IDXW-1:0] ext_idx,
  input  logic [XLEN-1:0] ext_data,
  input  logic            res_we,
  input  logic [IDXW-1:0] res_idx,
  input  logic [XLEN-1:0] res_data,
  input  logic            sp_bump,
  input  logic            pc_bump,
  input  logic [IDXW-1:0] ra_idx,
  output logic [XLEN-1:0] ra_data,
  input  logic [IDXW-1:0] rb_idx,
  output logic [XLEN-1:0] rb_data,
  input  logic [IDXW-1:0] rc_idx,
  output logic [XLEN-1:0] rc_data,
  output logic [XLEN-1:0] sp_val,
  output logic [XLEN-1:0] pc_val
);

  localparam int SP_STEP = NBYTES;
  localparam int PC_STEP = NBYTES / 2;

  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic adj_here;
    logic [XLEN-1:0] adj_val;
    if (g == SP_IDX) begin : g_sp
      assign adj_here = sp_bump;
      assign adj_val  = bump(regs[g], SP_STEP);
    end else if (g == PC_IDX) begin : g_pc
      assign adj_here = pc_bump;
      assign adj_val  = bump(regs[g], PC_STEP);
    end else begin : g_plain
      assign adj_here = 1'b0;
      assign adj_val  = regs[g];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                                   regs[g] <= '0;
      else if (adj_here)                            regs[g] <= adj_val;
      else if (res_we && res_idx == IDXW'(g))       regs[g] <= res_data;
      else if (ext_we && ext_idx == IDXW'(g))       regs[g] <= ext_data;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];
  assign rc_data = regs[rc_idx];
  assign sp_val  = regs[SP_IDX];
  assign pc_val  = regs[PC_IDX];

endmodule

// File: rtl/lsq_issue.sv
module lsq_issue
  import lsq_pkg::*;
#(
  parameter int AW = XLEN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [NBYTES-1:0] launch_flags,
  input  logic [AW-1:0]     launch_addr,
  output logic              rd_fire,
  output logic [AW-1:0]     rd_addr,
  output logic              cap_vld,
  output logic [SLOT_W-1:0] cap_slot,
  output logic [NBYTES-1:0] pend
);

  logic [NBYTES-1:0] pend_q;
  logic [AW-1:0]     addr_q;
  logic              cap_vld_q;
  logic [SLOT_W-1:0] cap_slot_q;

  assign rd_fire = |pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      addr_q     <= '0;
      cap_vld_q  <= 1'b0;
      cap_slot_q <= '0;
    end else if (launch) begin
      pend_q     <= launch_flags;
      addr_q     <= launch_addr;
      cap_vld_q  <= 1'b0;
    end else begin
      // The byte requested this cycle is taken one cycle later.
      cap_vld_q  <= rd_fire;
      cap_slot_q <= top_slot(pend_q);
      if (rd_fire) begin
        pend_q <= drop_top(pend_q);
        addr_q <= addr_q + AW'(1);
      end
    end
  end

  assign rd_addr  = addr_q;
  assign cap_vld  = cap_vld_q;
  assign cap_slot = cap_slot_q;
  assign pend     = pend_q;

endmodule

// File: rtl/lsq_assemble.sv
module lsq_assemble
  import lsq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap_vld,
  input  logic [SLOT_W-1:0] cap_slot,
  input  logic [7:0]        byte_in,
  input  load_kind_e        kind,
  output logic [XLEN-1:0]   result
);

  logic [XLEN-1:0] acc_q;
  logic [XLEN-1:0] merged;

  assign merged = cap_vld ? place_byte(acc_q, cap_slot, byte_in) : acc_q;
  assign result = finish_value(kind, merged);

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear)   acc_q <= '0;
    else if (cap_vld) acc_q <= merged;
  end

endmodule

// File: rtl/byteserial_load_seq.sv
module byteserial_load_seq
  import lsq_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int IDXW   = $clog2(NREG),
  parameter int SP_IDX = 14,
  parameter int PC_IDX = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [1:0]      cmd,
  input  logic [IDXW-1:0] src_a,
  input  logic [IDXW-1:0] src_b,
  input  logic [IDXW-1:0] dst,
  output logic            busy,
  output logic            done,
  output logic            mem_rd,
  output logic [XLEN-1:0] mem_addr,
  input  logic [7:0]      mem_rdata,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [XLEN-1:0] rd_data
);

  seq_state_e        state_q;
  load_kind_e        kind_q;
  load_kind_e        cmd_kind;
  logic [IDXW-1:0]   dst_q;

  // Named internal events (also observed by the bound checker).
  logic              accept;
  logic              last_cap;
  logic              res_we;
  logic              sp_bump;
  logic              pc_bump;
  logic              cap_vld;
  logic [SLOT_W-1:0] cap_slot;
  logic [NBYTES-1:0] pend_flags;

  logic [XLEN-1:0]   ra_data, rb_data, sp_val, pc_val;
  logic [XLEN-1:0]   first_addr;
  logic [XLEN-1:0]   result;
  logic              pend_empty;

  assign cmd_kind   = load_kind_e'(cmd);
  assign accept     = start && (state_q == SQ_IDLE);
  assign pend_empty = (pend_flags == '0);
  assign last_cap   = (state_q == SQ_RUN) && cap_vld && pend_empty;
  assign res_we     = last_cap;
  assign sp_bump    = last_cap && (kind_q == LK_POP);
  assign pc_bump    = (accept && cmd_kind == LK_IMM) || (last_cap && kind_q == LK_IMM);

  always_comb begin
    unique case (cmd_kind)
      LK_POP:  first_addr = sp_val;
      LK_IMM:  first_addr = pc_val;
      default: first_addr = ra_data + rb_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      kind_q  <= LK_BYTE;
      dst_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (accept) begin
          state_q <= SQ_RUN;
          kind_q  <= cmd_kind;
          dst_q   <= dst;
        end
        SQ_RUN:    if (last_cap) state_q <= SQ_RETIRE;
        SQ_RETIRE: state_q <= SQ_IDLE;
        default:   state_q <= SQ_IDLE;
      endcase
    end
  end

  lsq_regfile #(
    .NREG   (NREG),
    .IDXW   (IDXW),
    .SP_IDX (SP_IDX),
    .PC_IDX (PC_IDX)
  ) u_rf (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_we   (wr_en && (state_q == SQ_IDLE)),
    .ext_idx  (wr_idx),
    .ext_data (wr_data),
    .res_we   (res_we),
    .res_idx  (dst_q),
    .res_data (result),
    .sp_bump  (sp_bump),
    .pc_bump  (pc_bump),
    .ra_idx   (src_a),
    .ra_data  (ra_data),
    .rb_idx   (src_b),
    .rb_data  (rb_data),
    .rc_idx   (rd_idx),
    .rc_data  (rd_data),
    .sp_val   (sp_val),
    .pc_val   (pc_val)
  );

  lsq_issue #(
    .AW (XLEN)
  ) u_issue (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (accept),
    .launch_flags (flags_for(cmd_kind)),
    .launch_addr  (first_addr),
    .rd_fire      (mem_rd),
    .rd_addr      (mem_addr),
    .cap_vld      (cap_vld),
    .cap_slot     (cap_slot),
    .pend         (pend_flags)
  );

  lsq_assemble u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .cap_vld  (cap_vld),
    .cap_slot (cap_slot),
    .byte_in  (mem_rdata),
    .kind     (kind_q),
    .result   (result)
  );

  assign busy = (state_q != SQ_IDLE);
  assign done = (state_q == SQ_RETIRE);

endmodule

// File: rtl/lsq_checker.sv
module lsq_checker
  import lsq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic [XLEN-1:0]   mem_addr,
  input logic [NBYTES-1:0] pend_flags,
  input logic              cap_vld,
  input logic              res_we,
  input logic              sp_bump,
  input logic [1:0]        kind_q
);

  // R2: reads happen only inside a sequence
  p_read_in_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);

  // R2: one pending flag retires per cycle
  p_flags_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_flags != '0) |=> ($countones(pend_flags) == $countones($past(pend_flags)) - 1));

  // R3: back-to-back reads walk up by one byte
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + XLEN'(1)));

  // R4: stack pointer moves only for a pop
  p_sp_pop_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sp_bump |-> (kind_q == 2'd2));

  // R8: capture follows a read by one cycle
  p_cap_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |-> $past(mem_rd));

  // R8: done lasts exactly one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: the single destination write is followed by done
  p_write_then_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_we |=> done);

  // R10: no reads while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd);

endmodule

bind byteserial_load_seq lsq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .mem_rd     (mem_rd),
  .mem_addr   (mem_addr),
  .pend_flags (pend_flags),
  .cap_vld    (cap_vld),
  .res_we     (res_we),
  .sp_bump    (sp_bump),
  .kind_q     (kind_q)
);

// File: tb/tb_byteserial_load_seq.sv
`timescale 1ns/100ps
module tb_byteserial_load_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmd = '0;
  logic [3:0]  src_a = '0, src_b = '0, dst = '0;
  logic        busy, done, mem_rd;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_idx = '0;
  logic [31:0] rd_data;

  byteserial_load_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
    .src_a(src_a), .src_b(src_b), .dst(dst),
    .busy(busy), .done(done), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0, n_fail = 0, cyc = 0, rd_cnt = 0;
  logic [31:0] shadow [16];

  typedef struct {
    int          dst;
    int          kind;
    logic [31:0] dval, spv, pcv, base;
    int          nrd;
    int          t0;
  } exp_t;
  exp_t sb_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  // Memory model: byte content is a fixed function of the address.
  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= mbyte(mem_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(input int idx, input logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx[3:0]; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    shadow[idx] = v;
  endtask

  // Driver: predicts the outcome, pushes it, then issues the command.
  task automatic run_cmd(input int k, input int a, input int b, input int d, input bit intrude);
    exp_t it;
    logic [31:0] base, val, old_sp, old_pc, old_d;
    old_sp = shadow[14]; old_pc = shadow[15]; old_d = shadow[d];
    case (k)
      0, 1:    base = shadow[a] + shadow[b];
      2:       base = old_sp;
      default: base = old_pc;
    endcase
    if (k == 0) val = {24'h0, mbyte(base)};
    else        val = {mbyte(base), mbyte(base + 1), mbyte(base + 2), mbyte(base + 3)};
    shadow[d] = val;
    if (k == 2) shadow[14] = old_sp + 32'd4;
    if (k == 3) shadow[15] = old_pc + 32'd4;
    it.dst = d; it.kind = k; it.dval = shadow[d];
    it.spv = shadow[14]; it.pcv = shadow[15]; it.base = base;
    it.nrd = (k == 0) ? 1 : 4;
    @(negedge clk);
    start = 1'b1; cmd = k[1:0]; src_a = a[3:0]; src_b = b[3:0]; dst = d[3:0];
    @(posedge clk);
    #1;
    it.t0 = cyc;
    sb_q.push_back(it);
    @(negedge clk);
    start = 1'b0;
    if (!(k == 3 && d == 15)) begin
      rd_idx = d[3:0]; #0.5;
      chk(rd_data == old_d, "R9 destination unchanged mid-sequence", rd_data, old_d);
    end
    if (k == 3) begin
      rd_idx = 4'd15; #0.5;
      chk(rd_data == old_pc + 32'd2, "R5 first pc step", rd_data, old_pc + 32'd2);
    end
    if (intrude) begin
      @(negedge clk);
      start = 1'b1; cmd = 2'd0; wr_en = 1'b1; wr_idx = 4'd10; wr_data = 32'hDEAD_0000;
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares addresses, read count, latency and final registers.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_rd) begin
        if (sb_q.size() != 0)
          chk(mem_addr == sb_q[0].base + rd_cnt, "R3 read address", mem_addr, sb_q[0].base + rd_cnt);
        rd_cnt++;
      end
      if (done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t it;
          it = sb_q[0];
          chk(cyc - it.t0 == it.nrd + 1, "R8 done latency", cyc - it.t0, it.nrd + 1);
          chk(rd_cnt == it.nrd, "R2 read count", rd_cnt, it.nrd);
          rd_idx = it.dst[3:0]; #0.5;
          if (it.dst >= 14 && it.kind >= 2)
            chk(rd_data == it.dval, "R11 pointer step wins", rd_data, it.dval);
          else if (it.kind == 0)
            chk(rd_data == it.dval, "R7 zero-extended byte", rd_data, it.dval);
          else
            chk(rd_data == it.dval, "R6 big-endian word", rd_data, it.dval);
          rd_idx = 4'd14; #0.5;
          chk(rd_data == it.spv, "R4 stack pointer", rd_data, it.spv);
          rd_idx = 4'd15; #0.5;
          chk(rd_data == it.pcv, "R5 program counter", rd_data, it.pcv);
          void'(sb_q.pop_front());
        end
        rd_cnt = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy, "R1 busy after reset", busy, 0);
    chk(!done, "R1 done after reset", done, 0);
    chk(!mem_rd, "R1 mem_rd after reset", mem_rd, 0);
    for (int i = 0; i < 16; i++) begin
      rd_idx = i[3:0]; #0.5;
      chk(rd_data == 32'd0, "R1 register zero", rd_data, 0);
    end
    // R12 idle write and read
    wreg(1, 32'h0000_0100);
    wreg(2, 32'h0000_0023);
    rd_idx = 4'd1; #0.5;
    chk(rd_data == 32'h100, "R12 write then read", rd_data, 32'h100);
    // R2 R3 R7 byte load
    run_cmd(0, 1, 2, 3, 1'b0);
    // R6 word load with wrapping sum
    wreg(4, 32'hFFFF_FFF0);
    wreg(5, 32'h0000_001E);
    run_cmd(1, 4, 5, 6, 1'b0);
    // R4 pop
    wreg(14, 32'h0000_2000);
    run_cmd(2, 0, 0, 7, 1'b0);
    // R5 immediate load
    wreg(15, 32'h0000_0400);
    run_cmd(3, 0, 0, 8, 1'b0);
    // R10 start and write port ignored while busy
    wreg(10, 32'h0000_1234);
    run_cmd(1, 1, 2, 9, 1'b1);
    rd_idx = 4'd10; #0.5;
    chk(rd_data == 32'h1234, "R10 write ignored while busy", rd_data, 32'h1234);
    chk(!busy && !done, "R10 no second sequence", {30'd0, busy, done}, 0);
    // R11 pointer conflicts
    run_cmd(2, 0, 0, 14, 1'b0);
    run_cmd(3, 0, 0, 15, 1'b0);
    // Mixed patterns
    for (int i = 0; i < 8; i++) begin
      wreg(11, 32'h0001_0000 + i * 32'd37);
      wreg(12, 32'h0000_0F00 - i * 32'd91);
      run_cmd(i % 4, 11, 12, 1 + (i % 9), 1'b0);
    end
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule